// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block cleans up one general-purpose input pin before it is used as a level or as an interrupt source. The raw pin is first brought into the system clock domain by a two-flop synchronizer. A small state machine then compares the synchronized level with the filtered output. The time a new level must persist is counted in ticks of a slow real-time clock. That clock arrives as a one-cycle enable pulse, `rtc_tick`, in the system clock domain.

Software sets up the filter by presenting a mode, a 4-bit window length and a 2-bit range on the configuration inputs and pulsing `cfg_wr`. The range sets how many RTC pulses make up one window tick. The mode picks one of four behaviours:

- Glitches of both polarities are removed.
- Low pulses are kept and only the return to high is filtered.
- High pulses are kept and only the return to low is filtered.
- Filtering is bypassed.

A configuration write can also start an optional hold-off period. During hold-off the `settling` output is high and the filtered level is frozen.

Filter states: `FLT_STABLE` (the output agrees with the input, or is being updated at once) and `FLT_TIMING` (a filtered transition is waiting for its window). Transitions:

- STABLE to TIMING when the input differs from the output in a filtered direction.
- TIMING to STABLE on a bounce back to the output level, on window expiry (the output takes the new level), on a configuration write, or while settling.

Hold-off states: `HO_IDLE` and `HO_HOLD`. IDLE goes to HOLD on a configuration write that has hold-off enabled and a non-zero length. HOLD goes back to IDLE when the length in RTC pulses has elapsed, or on a configuration write without hold-off.

Top module: `gpio_debounce_filter`

## Requirements
- R1: The pin passes two synchronizer flops and the output register. In bypass mode, a change on `pin_raw` set up before clock edge n appears on `pin_filt` after edge n+2, and not earlier.
- R2: After reset `pin_filt` is 0, `settling` is 0 and the latched mode is bypass (00), with length 0 and range 0.
- R3: `cfg_mode`, `cfg_len` and `cfg_range` are latched only on a clock edge with `cfg_wr` high, and take effect from the next edge. Mode encoding: 00 = bypass, 01 = keep low pulses, 10 = keep high pulses, 11 = remove both. Range bit 0 is the fine-unit select and bit 1 is the large-unit select.
- R4: One window tick lasts 2, 8, 512 or 2048 RTC pulses for range 00, 01, 10 and 11 respectively. Pulse counting restarts each time timing starts.
- R5: In mode 11 the output takes a new level only after the synchronized input has held it for `cfg_len` window ticks. The output changes on the edge that sees the last tick.
- R6: Any return of the synchronized input to the output level while timing cancels the window, and the next transition starts a fresh count.
- R7: In mode 01 a falling input reaches the output on the next edge. A rising input is debounced as in R5.
- R8: In mode 10 a rising input reaches the output on the next edge. A falling input is debounced as in R5.
- R9: A window length of 0 with a filtering mode behaves as a length of 1 tick.
- R10: A write with `cfg_hold_en` high and a non-zero `cfg_hold_len` raises `settling` after that edge. `settling` falls after the edge that sees the `cfg_hold_len`-th following RTC pulse. A write with hold-off disabled or a zero length clears `settling`.
- R11: While `settling` is high `pin_filt` does not change, and any window in progress is discarded.
- R12: A configuration write discards any window in progress and leaves `pin_filt` unchanged on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Unsynchronized pin level |
| rtc_tick | input | 1 | One-cycle pulse per real-time clock period |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Filter mode (R3 encoding) |
| cfg_len | input | LEN_W (4) | Window length in ticks |
| cfg_range | input | 2 | Tick range select |
| cfg_hold_en | input | 1 | Start a hold-off with this write |
| cfg_hold_len | input | HOLD_W (12) | Hold-off length in RTC pulses |
| pin_filt | output | 1 | Filtered pin level |
| settling | output | 1 | Hold-off in progress |

## Verification
Some properties are checked on every cycle by the assertions:

- In mode 11 the output only moves out of the timing state.
- Kept polarities propagate on the next edge.
- The output is frozen while settling and across a configuration write.
- The prescaler stays inside its range and starts from zero.
- `settling` only rises after a write.

The exact length of each window for the four ranges, the restart after a bounce, the zero-length case and the hold-off duration depend on counting RTC pulses across thousands of cycles. Only the bench's scenarios, compared against a cycle-accurate reference model, can show these.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    typedef enum logic [1:0] {
        DB_BYPASS    = 2'b00,
        DB_KEEP_LOW  = 2'b01,
        DB_KEEP_HIGH = 2'b10,
        DB_BOTH      = 2'b11
    } db_mode_e;

    typedef enum logic {
        FLT_STABLE = 1'b0,
        FLT_TIMING = 1'b1
    } flt_state_e;

    typedef enum logic {
        HO_IDLE = 1'b0,
        HO_HOLD = 1'b1
    } ho_state_e;

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/dbf_prescaler.sv
module dbf_prescaler #(
    parameter int SHIFT0 = 1,
    parameter int SHIFT1 = 3,
    parameter int SHIFT2 = 9,
    parameter int SHIFT3 = 11,
    parameter int PRE_W  = SHIFT3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       rtc_tick,
    input  logic [1:0] rng,
    output logic       unit_tick
);
    localparam int NRANGE = 4;

    logic [PRE_W-1:0] last_tab [NRANGE];
    logic [PRE_W-1:0] last;
    logic [PRE_W-1:0] pre_q;

    // One terminal count per range setting
    for (genvar g = 0; g < NRANGE; g++) begin : g_last
        localparam int SH = (g == 0) ? SHIFT0 : (g == 1) ? SHIFT1 :
                            (g == 2) ? SHIFT2 : SHIFT3;
        assign last_tab[g] = PRE_W'((1 << SH) - 1);
    end

    assign last      = last_tab[rng];
    assign unit_tick = run && rtc_tick && (pre_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pre_q <= '0;
        else if (!run)     pre_q <= '0;
        else if (rtc_tick) pre_q <= (pre_q == last) ? '0 : pre_q + 1'b1;
    end

    // R4: the pulse counter never passes the terminal count of the range
    a_r4_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> pre_q <= last);
    // R4: every window starts counting RTC pulses from zero
    a_r4_pre_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$past(run)) |-> pre_q == '0);
endmodule

// File: rtl/dbf_holdoff.sv
module dbf_holdoff
    import dbf_pkg::*;
#(
    parameter int HOLD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              hold_en,
    input  logic [HOLD_W-1:0] hold_len,
    input  logic              rtc_tick,
    output logic              settling
);
    ho_state_e         st_q, st_d;
    logic [HOLD_W-1:0] left_q, left_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= HO_IDLE;
            left_q <= '0;
        end else begin
            st_q   <= st_d;
            left_q <= left_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        left_d = left_q;
        if (cfg_wr) begin
            st_d   = (hold_en && (hold_len != '0)) ? HO_HOLD : HO_IDLE;
            left_d = hold_len;
        end else begin
            unique case (st_q)
                HO_IDLE: left_d = left_q;
                HO_HOLD: if (rtc_tick) begin
                    left_d = left_q - 1'b1;
                    if (left_q == HOLD_W'(1)) st_d = HO_IDLE;
                end
            endcase
        end
    end

    assign settling = (st_q == HO_HOLD);

    // R10: hold-off is entered only through a configuration write
    a_r10_rise_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settling) |-> $past(cfg_wr));
    // R10: remaining length is never exhausted while still holding
    a_r10_left_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        settling |-> left_q != '0);
endmodule

// File: rtl/dbf_filter_fsm.sv
module dbf_filter_fsm
    import dbf_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  db_mode_e         mode,
    input  logic [LEN_W-1:0] len,
    input  logic             cfg_wr,
    input  logic             settling,
    input  logic             unit_tick,
    output logic             run,
    output logic             filt_o
);
    localparam int CNT_W = LEN_W + 1;

    flt_state_e       st_q, st_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic             out_q, out_d;
    logic [CNT_W-1:0] eff_len;
    logic [CNT_W-1:0] cnt_nxt;
    logic             pass_now;

    assign eff_len  = (len == '0) ? CNT_W'(1) : {1'b0, len};
    assign cnt_nxt  = {1'b0, cnt_q} + CNT_W'(1);
    assign pass_now = ((mode == DB_KEEP_LOW)  && !sync_in) ||
                      ((mode == DB_KEEP_HIGH) &&  sync_in);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FLT_STABLE;
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            out_q <= out_d;
        end
    end

    // Next state and output level
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        out_d = out_q;
        if (cfg_wr || settling) begin
            st_d  = FLT_STABLE;
            cnt_d = '0;
        end else if (mode == DB_BYPASS) begin
            st_d  = FLT_STABLE;
            cnt_d = '0;
            out_d = sync_in;
        end else begin
            unique case (st_q)
                FLT_STABLE: begin
                    cnt_d = '0;
                    if (sync_in != out_q) begin
                        if (pass_now) out_d = sync_in;
                        else          st_d  = FLT_TIMING;
                    end
                end
                FLT_TIMING: begin
                    if (sync_in == out_q) begin
                        st_d  = FLT_STABLE;
                        cnt_d = '0;
                    end else if (unit_tick) begin
                        if (cnt_nxt >= eff_len) begin
                            out_d = sync_in;
                            st_d  = FLT_STABLE;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_nxt[LEN_W-1:0];
                        end
                    end
                end
            endcase
        end
    end

    assign run    = (st_q == FLT_TIMING);
    assign filt_o = out_q;

    // R5: in remove-both mode the output moves only at the end of a window
    a_r5_move_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DB_BOTH && !$stable(out_q)) |-> $past(st_q) == FLT_TIMING);
    // R7: kept low pulse propagates on the next edge
    a_r7_low_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DB_KEEP_LOW && !cfg_wr && !settling && out_q && !sync_in) |=> !out_q);
    // R8: kept high pulse propagates on the next edge
    a_r8_high_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DB_KEEP_HIGH && !cfg_wr && !settling && !out_q && sync_in) |=> out_q);
    // R11: output frozen during hold-off
    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        settling |=> $stable(out_q));
    // R12: a write cancels timing and keeps the output
    a_r12_write_resets: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (st_q == FLT_STABLE) && $stable(out_q));
endmodule

// File: rtl/gpio_debounce_filter.sv
module gpio_debounce_filter
    import dbf_pkg::*;
#(
    parameter int LEN_W       = 4,
    parameter int HOLD_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int SHIFT0      = 1,
    parameter int SHIFT1      = 3,
    parameter int SHIFT2      = 9,
    parameter int SHIFT3      = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_raw,
    input  logic              rtc_tick,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_mode,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [1:0]        cfg_range,
    input  logic              cfg_hold_en,
    input  logic [HOLD_W-1:0] cfg_hold_len,
    output logic              pin_filt,
    output logic              settling
);
    localparam int PRE_W = SHIFT3;

    db_mode_e         mode_q;
    logic [LEN_W-1:0] len_q;
    logic [1:0]       rng_q;
    logic             sync_lvl;
    logic             run;
    logic             unit_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= DB_BYPASS;
            len_q  <= '0;
            rng_q  <= '0;
        end else if (cfg_wr) begin
            mode_q <= db_mode_e'(cfg_mode);
            len_q  <= cfg_len;
            rng_q  <= cfg_range;
        end
    end

    dbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d (pin_raw),
        .q (sync_lvl)
    );

    dbf_prescaler #(
        .SHIFT0 (SHIFT0), .SHIFT1 (SHIFT1), .SHIFT2 (SHIFT2), .SHIFT3 (SHIFT3),
        .PRE_W (PRE_W)
    ) u_pre (
        .clk (clk),
        .rst_n (rst_n),
        .run (run),
        .rtc_tick (rtc_tick),
        .rng (rng_q),
        .unit_tick (unit_tick)
    );

    dbf_holdoff #(.HOLD_W(HOLD_W)) u_hold (
        .clk (clk),
        .rst_n (rst_n),
        .cfg_wr (cfg_wr),
        .hold_en (cfg_hold_en),
        .hold_len (cfg_hold_len),
        .rtc_tick (rtc_tick),
        .settling (settling)
    );

    dbf_filter_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk (clk),
        .rst_n (rst_n),
        .sync_in (sync_lvl),
        .mode (mode_q),
        .len (len_q),
        .cfg_wr (cfg_wr),
        .settling (settling),
        .unit_tick (unit_tick),
        .run (run),
        .filt_o (pin_filt)
    );

    // R3: the latched configuration only moves on a write
    a_r3_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_wr) |-> ($stable(mode_q) && $stable(len_q) && $stable(rng_q)));
endmodule

// File: tb/gpio_debounce_filter_tb.sv
module gpio_debounce_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_raw = 1'b0;
    logic        rtc_tick = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [3:0]  cfg_len = 4'd0;
    logic [1:0]  cfg_range = 2'b00;
    logic        cfg_hold_en = 1'b0;
    logic [11:0] cfg_hold_len = 12'd0;
    logic        pin_filt;
    logic        settling;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    string phase = "R2";

    gpio_debounce_filter u_dut (
        .clk (clk), .rst_n (rst_n), .pin_raw (pin_raw), .rtc_tick (rtc_tick),
        .cfg_wr (cfg_wr), .cfg_mode (cfg_mode), .cfg_len (cfg_len),
        .cfg_range (cfg_range), .cfg_hold_en (cfg_hold_en),
        .cfg_hold_len (cfg_hold_len), .pin_filt (pin_filt), .settling (settling)
    );

    always #5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_s1 = 0, m_s2 = 0, m_out = 0, m_timing = 0, m_pre = 0, m_cnt = 0;
    int m_mode = 0, m_len = 0, m_rng = 0, m_set = 0, m_left = 0;

    function automatic int ticks_per_unit(int r);
        case (r)
            0: return 2;
            1: return 8;
            2: return 512;
            default: return 2048;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_out = 0; m_timing = 0; m_pre = 0; m_cnt = 0;
            m_mode = 0; m_len = 0; m_rng = 0; m_set = 0; m_left = 0;
        end else begin
            int lvl, per, win, tk, n_out, n_timing, n_pre, n_cnt, n_set, n_left;
            lvl  = m_s2;
            per  = ticks_per_unit(m_rng);
            win  = (m_len == 0) ? 1 : m_len;
            tk   = (m_timing && rtc_tick && m_pre == per - 1) ? 1 : 0;
            n_out = m_out; n_timing = m_timing; n_cnt = m_cnt;
            n_pre = !m_timing ? 0 : (rtc_tick ? (m_pre + 1) % per : m_pre);
            if (cfg_wr || m_set) begin
                n_timing = 0; n_cnt = 0;
            end else if (m_mode == 0) begin
                n_timing = 0; n_cnt = 0; n_out = lvl;
            end else if (!m_timing) begin
                n_cnt = 0;
                if (lvl != m_out) begin
                    if ((m_mode == 1 && lvl == 0) || (m_mode == 2 && lvl == 1)) n_out = lvl;
                    else n_timing = 1;
                end
            end else begin
                if (lvl == m_out) begin
                    n_timing = 0; n_cnt = 0;
                end else if (tk) begin
                    if (m_cnt + 1 >= win) begin
                        n_out = lvl; n_timing = 0; n_cnt = 0;
                    end else n_cnt = m_cnt + 1;
                end
            end
            n_set = m_set; n_left = m_left;
            if (cfg_wr) begin
                n_set  = (cfg_hold_en && cfg_hold_len != 0) ? 1 : 0;
                n_left = cfg_hold_len;
            end else if (m_set && rtc_tick) begin
                if (m_left == 1) n_set = 0;
                n_left = m_left - 1;
            end
            if (cfg_wr) begin
                m_mode = cfg_mode; m_len = cfg_len; m_rng = cfg_range;
            end
            m_s2 = m_s1; m_s1 = pin_raw;
            m_out = n_out; m_timing = n_timing; m_pre = n_pre; m_cnt = n_cnt;
            m_set = n_set; m_left = n_left;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_checks++;
            if (pin_filt !== m_out[0] || settling !== m_set[0]) begin
                n_fail++;
                $display("FAIL %s: pin_filt=%0b settling=%0b expected %0d %0d at %0t",
                         phase, pin_filt, settling, m_out, m_set, $time);
            end
        end
    end

    // RTC pulse: one clock in every three
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            rtc_tick = (div == 2);
            div = (div + 1) % 3;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_lvl(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(input logic [1:0] md, input logic [3:0] ln, input logic [1:0] rg,
                             input logic hen, input logic [11:0] hl);
        cfg_mode = md; cfg_len = ln; cfg_range = rg; cfg_hold_en = hen; cfg_hold_len = hl;
        cfg_wr = 1'b1;
        step(1);
        cfg_wr = 1'b0;
        cfg_mode = 2'b00; cfg_len = 4'd0; cfg_range = 2'b00; cfg_hold_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        step(4);
        // R2: reset state
        expect_lvl("R2", pin_filt, 1'b0);
        expect_lvl("R2", settling, 1'b0);
        rst_n = 1'b1;
        step(2);

        // R1: bypass latency of three edges
        phase = "R1";
        pin_raw = 1'b1;
        step(2);
        expect_lvl("R1", pin_filt, 1'b0);
        step(1);
        expect_lvl("R1", pin_filt, 1'b1);
        pin_raw = 1'b0;
        step(5);

        // R3: fields are ignored without a write strobe
        phase = "R3";
        cfg_mode = 2'b11; cfg_len = 4'd9;
        pin_raw = 1'b1;
        step(3);
        expect_lvl("R3", pin_filt, 1'b1);
        cfg_mode = 2'b00; cfg_len = 4'd0;
        pin_raw = 1'b0;
        step(4);

        // R5: remove-both, length 3, range 00
        phase = "R5";
        write_cfg(2'b11, 4'd3, 2'b00, 1'b0, 12'd0);
        pin_raw = 1'b1; step(4); pin_raw = 1'b0; step(30);
        expect_lvl("R5", pin_filt, 1'b0);
        pin_raw = 1'b1; step(40);
        expect_lvl("R5", pin_filt, 1'b1);

        // R6: bounce restarts the window
        phase = "R6";
        pin_raw = 1'b0; step(10); pin_raw = 1'b1; step(3); pin_raw = 1'b0; step(12);
        pin_raw = 1'b1; step(2); pin_raw = 1'b0; step(40);
        expect_lvl("R6", pin_filt, 1'b0);

        // R4: the four tick ranges
        phase = "R4";
        write_cfg(2'b11, 4'd2, 2'b01, 1'b0, 12'd0);
        pin_raw = 1'b1; step(80);
        write_cfg(2'b11, 4'd1, 2'b10, 1'b0, 12'd0);
        pin_raw = 1'b0; step(1700);
        expect_lvl("R4", pin_filt, 1'b0);
        write_cfg(2'b11, 4'd1, 2'b11, 1'b0, 12'd0);
        pin_raw = 1'b1; step(6000);
        expect_lvl("R4", pin_filt, 1'b0);
        step(400);
        expect_lvl("R4", pin_filt, 1'b1);

        // R9: length 0 acts as one tick
        phase = "R9";
        write_cfg(2'b11, 4'd0, 2'b00, 1'b0, 12'd0);
        pin_raw = 1'b0; step(15);
        expect_lvl("R9", pin_filt, 1'b0);

        // R7: keep low pulses
        phase = "R7";
        write_cfg(2'b00, 4'd0, 2'b00, 1'b0, 12'd0);
        pin_raw = 1'b1; step(5);
        write_cfg(2'b01, 4'd4, 2'b00, 1'b0, 12'd0);
        pin_raw = 1'b0; step(3);
        expect_lvl("R7", pin_filt, 1'b0);
        pin_raw = 1'b1; step(6);
        expect_lvl("R7", pin_filt, 1'b0);
        step(40);

        // R8: keep high pulses
        phase = "R8";
        write_cfg(2'b10, 4'd4, 2'b00, 1'b0, 12'd0);
        pin_raw = 1'b0; step(40);
        pin_raw = 1'b1; step(3);
        expect_lvl("R8", pin_filt, 1'b1);
        pin_raw = 1'b0; step(6);
        expect_lvl("R8", pin_filt, 1'b1);
        step(40);

        // R10 and R11: hold-off freezes the output
        phase = "R10";
        write_cfg(2'b00, 4'd0, 2'b00, 1'b1, 12'd5);
        expect_lvl("R10", settling, 1'b1);
        phase = "R11";
        pin_raw = 1'b1; step(8);
        expect_lvl("R11", pin_filt, 1'b0);
        step(20);
        expect_lvl("R10", settling, 1'b0);
        expect_lvl("R11", pin_filt, 1'b1);
        phase = "R10";
        write_cfg(2'b11, 4'd2, 2'b00, 1'b1, 12'd40);
        step(10);
        write_cfg(2'b11, 4'd2, 2'b00, 1'b0, 12'd0);
        expect_lvl("R10", settling, 1'b0);

        // R12: a write in mid-window restarts it
        phase = "R12";
        pin_raw = 1'b0; step(8);
        write_cfg(2'b11, 4'd2, 2'b00, 1'b0, 12'd0);
        step(6);
        expect_lvl("R12", pin_filt, 1'b1);
        step(30);
        expect_lvl("R12", pin_filt, 1'b0);

        step(5);
        finish_run();
    end
endmodule